// File: doc/BRIEF.md
# Multi-order sinc decimation filter

This block turns the one-bit output of a delta-sigma modulator into signed conversion words. A chain of three wrap-around integrators runs at the modulator rate. At the end of every decimation period, a set of differencing stages produces first-, second- and third-order boxcar sums. The first-order sum settles in one conversion and gives the fast-settling response. The second-order sum needs two conversions to settle and the third-order sum needs three. Each conversion word comes from one of these orders, selected by the filter mode. Before output, every order is rescaled to the same full scale, so changing the order does not change the gain.

An automatic mode is meant for use after the input channel or amplifier gain changes. The first conversion after a reconfiguration pulse uses the first-order sum, the second conversion uses the second-order sum, and every later conversion uses the third-order sum. The system therefore gets a usable reading quickly and the low-noise response once the longer filters have settled. The decimation ratio and the mode are captured only on the reconfiguration pulse. The same pulse clears all filter state.

Top module: `sinc_decim`

## Requirements
- R1: While reset is asserted and after reset is released, `result` is 0 and `result_valid` is 0 until a conversion completes. After reset the captured ratio is `DEF_RATIO` and the captured mode is `DEF_MODE`.
- R2: Only cycles with `mod_en` high and `reconfig` low consume a modulator bit. After exactly R such cycles, where R is the captured ratio, `result_valid` pulses once, in the cycle after the R-th consumed bit.
- R3: In mode 0 (fast), a word equals 2·R²·S1 − R³. S1 is the number of ones among the last R consumed bits.
- R4: In mode 1 (sinc2), a word equals 2·R·S2 − R³. S2 is the last 2R−1 consumed bits weighted by the convolution of two length-R boxcars, with the newest bit at lag 0.
- R5: In mode 2 (sinc3), a word equals 2·S3 − R³. S3 uses weights from three convolved length-R boxcars over the last 3R−2 bits.
- R6: In mode 3 (automatic), conversion 1 after a reconfiguration follows R3, conversion 2 follows R4, and conversion 3 and all later conversions follow R5.
- R7: A `reconfig` pulse clears every integrator and differencing state and restarts the decimation count. Bits that arrived before the pulse count as zeros. A bit offered in the same cycle is discarded. No strobe follows the pulse.
- R8: `dec_ratio` and `filt_mode` are sampled only in a `reconfig` cycle. Changing them at any other time has no effect on the output.
- R9: A captured ratio below 2 is treated as 2.
- R10: `result_valid` never stays high for two consecutive cycles. `result` holds its value between strobes.
- R11: Every order maps an all-ones input to +R³ and an all-zeros input to −R³ once it has settled, including when the integrators wrap around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Modulator-rate enable: consume `mod_bit` this cycle |
| mod_bit | input | 1 | Modulator output bit |
| dec_ratio | input | RATIO_W | Decimation ratio, captured on `reconfig` |
| filt_mode | input | 2 | 0 fast, 1 sinc2, 2 sinc3, 3 automatic; captured on `reconfig` |
| reconfig | input | 1 | Channel or gain change: clear state, capture configuration |
| result | output | 3·RATIO_W+2 | Signed conversion word, full scale ±R³ |
| result_valid | output | 1 | One-cycle strobe marking a new `result` |

## Verification
The bench builds the block with RATIO_W = 4 and DEF_RATIO = 4, which gives 13-bit integrators. A long all-ones run at the largest ratio, 15, therefore makes the third integrator wrap many times, and correct words then depend on modular differencing. The small width also lets the ratio sweep cover the clamp values 0 and 1, the smallest working ratio and the largest one. Gapped enables check that idle cycles do not advance the count. A reconfiguration in the middle of a conversion shows that all earlier history is discarded.

// File: rtl/sincdec_pkg.sv
package sincdec_pkg;

  typedef enum logic [1:0] {
    MODE_FAST  = 2'd0,
    MODE_SINC2 = 2'd1,
    MODE_SINC3 = 2'd2,
    MODE_AUTO  = 2'd3
  } filt_mode_e;

  // Highest filter order supported by the integrator and differencing chains
  localparam int MAX_ORDER = 3;

  // Smallest decimation ratio the counter accepts
  localparam int MIN_RATIO = 2;

endpackage

// File: rtl/sincdec_ctrl.sv
module sincdec_ctrl
  import sincdec_pkg::*;
#(
  parameter int         RATIO_W   = 8,
  parameter int         DEF_RATIO = 64,
  parameter logic [1:0] DEF_MODE  = 2'd2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mod_en,
  input  logic               reconfig,
  input  logic [RATIO_W-1:0] ratio_in,
  input  logic [1:0]         mode_in,
  output logic               dump,
  output logic [1:0]         order,
  output logic [RATIO_W-1:0] ratio_q
);

  localparam logic [RATIO_W-1:0] RMIN = RATIO_W'(MIN_RATIO);
  localparam logic [RATIO_W-1:0] RDEF = RATIO_W'(DEF_RATIO);

  filt_mode_e         mode_q, mode_d;
  logic [RATIO_W-1:0] ratio_d;
  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic [1:0]         conv_q, conv_d;

  // next-state logic
  always_comb begin
    ratio_d = ratio_q;
    mode_d  = mode_q;
    cnt_d   = cnt_q;
    conv_d  = conv_q;
    dump    = 1'b0;
    if (reconfig) begin
      ratio_d = (ratio_in < RMIN) ? RMIN : ratio_in;
      mode_d  = filt_mode_e'(mode_in);
      cnt_d   = '0;
      conv_d  = '0;
    end else if (mod_en) begin
      if (cnt_q == ratio_q - RATIO_W'(1)) begin
        dump  = 1'b1;
        cnt_d = '0;
        if (conv_q != 2'd3) conv_d = conv_q + 2'd1;
      end else begin
        cnt_d = cnt_q + RATIO_W'(1);
      end
    end
  end

  // filter order for the conversion that completes this cycle
  always_comb begin
    unique case (mode_q)
      MODE_FAST:  order = 2'd1;
      MODE_SINC2: order = 2'd2;
      MODE_SINC3: order = 2'd3;
      default: begin
        if (conv_q == 2'd0)      order = 2'd1;
        else if (conv_q == 2'd1) order = 2'd2;
        else                     order = 2'd3;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= RDEF;
      mode_q  <= filt_mode_e'(DEF_MODE);
      cnt_q   <= '0;
      conv_q  <= '0;
    end else begin
      ratio_q <= ratio_d;
      mode_q  <= mode_d;
      cnt_q   <= cnt_d;
      conv_q  <= conv_d;
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_en && !reconfig) |=> $stable(cnt_q));

  // R9
  ratio_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_q >= RMIN);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reconfig |=> ($stable(ratio_q) && $stable(mode_q)));

endmodule

// File: rtl/sincdec_integ.sv
module sincdec_integ
  import sincdec_pkg::*;
#(
  parameter int ACC_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample_en,
  input  logic             mod_bit,
  output logic [ACC_W-1:0] acc_nxt [MAX_ORDER]
);

  logic [ACC_W-1:0] acc_q [MAX_ORDER];

  // cascaded wrap-around sums, each fed by the updated value of the stage before it
  always_comb begin
    logic [ACC_W-1:0] run;
    run = {{(ACC_W-1){1'b0}}, mod_bit};
    for (int g = 0; g < MAX_ORDER; g++) begin
      run        = acc_q[g] + run;
      acc_nxt[g] = run;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < MAX_ORDER; g++) acc_q[g] <= '0;
    end else if (clear) begin
      for (int g = 0; g < MAX_ORDER; g++) acc_q[g] <= '0;
    end else if (sample_en) begin
      for (int g = 0; g < MAX_ORDER; g++) acc_q[g] <= acc_nxt[g];
    end
  end

  for (genvar g = 0; g < MAX_ORDER; g++) begin : g_chk
    // R7
    integ_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (acc_q[g] == '0));
  end

endmodule

// File: rtl/sincdec_comb.sv
module sincdec_comb
  import sincdec_pkg::*;
#(
  parameter int ACC_W   = 25,
  parameter int RATIO_W = 8,
  parameter int OUT_W   = 26
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    dump,
  input  logic [1:0]              order,
  input  logic [RATIO_W-1:0]      ratio,
  input  logic [ACC_W-1:0]        acc_nxt [MAX_ORDER],
  output logic signed [OUT_W-1:0] result,
  output logic                    result_valid
);

  logic [ACC_W-1:0]        dly_q [MAX_ORDER][MAX_ORDER];
  logic [ACC_W-1:0]        stg   [MAX_ORDER][MAX_ORDER];
  logic [ACC_W-1:0]        yv    [MAX_ORDER];
  logic [OUT_W-1:0]        r1, r2, r3, scaled;
  logic signed [OUT_W-1:0] res_d;

  // differencing chains: order g+1 uses g+1 stages on integrator g
  always_comb begin
    logic [ACC_W-1:0] run;
    for (int g = 0; g < MAX_ORDER; g++) begin
      run = acc_nxt[g];
      for (int s = 0; s < MAX_ORDER; s++) begin
        stg[g][s] = run;
        if (s <= g) run = run - dly_q[g][s];
      end
      yv[g] = run;
    end
  end

  // bring each order to full scale R^3, then make it bipolar
  always_comb begin
    r1 = OUT_W'(ratio);
    r2 = r1 * r1;
    r3 = r2 * r1;
    unique case (order)
      2'd1:    scaled = OUT_W'(yv[0]) * r2;
      2'd2:    scaled = OUT_W'(yv[1]) * r1;
      default: scaled = OUT_W'(yv[2]);
    endcase
    res_d = $signed((scaled << 1) - r3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < MAX_ORDER; g++)
        for (int s = 0; s < MAX_ORDER; s++) dly_q[g][s] <= '0;
    end else if (clear) begin
      for (int g = 0; g < MAX_ORDER; g++)
        for (int s = 0; s < MAX_ORDER; s++) dly_q[g][s] <= '0;
    end else if (dump) begin
      for (int g = 0; g < MAX_ORDER; g++)
        for (int s = 0; s < MAX_ORDER; s++) dly_q[g][s] <= stg[g][s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= dump;
      if (dump) result <= res_d;
    end
  end

  // R10
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result));

  // R7
  reconfig_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !result_valid);

  // R11
  full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> ((result <= $signed(r3)) && (result >= -$signed(r3))));

endmodule

// File: rtl/sinc_decim.sv
module sinc_decim
  import sincdec_pkg::*;
#(
  parameter int         RATIO_W   = 8,
  parameter int         DEF_RATIO = 64,
  parameter logic [1:0] DEF_MODE  = 2'd2,
  localparam int        OUT_W     = MAX_ORDER * RATIO_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mod_en,
  input  logic                    mod_bit,
  input  logic [RATIO_W-1:0]      dec_ratio,
  input  logic [1:0]              filt_mode,
  input  logic                    reconfig,
  output logic signed [OUT_W-1:0] result,
  output logic                    result_valid
);

  localparam int ACC_W = MAX_ORDER * RATIO_W + 1;

  logic               dump;
  logic [1:0]         order;
  logic [RATIO_W-1:0] ratio_q;
  logic               sample_en;
  logic [ACC_W-1:0]   acc_nxt [MAX_ORDER];

  assign sample_en = mod_en & ~reconfig;

  sincdec_ctrl #(
    .RATIO_W  (RATIO_W),
    .DEF_RATIO(DEF_RATIO),
    .DEF_MODE (DEF_MODE)
  ) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mod_en  (mod_en),
    .reconfig(reconfig),
    .ratio_in(dec_ratio),
    .mode_in (filt_mode),
    .dump    (dump),
    .order   (order),
    .ratio_q (ratio_q)
  );

  sincdec_integ #(
    .ACC_W(ACC_W)
  ) integ_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (reconfig),
    .sample_en(sample_en),
    .mod_bit  (mod_bit),
    .acc_nxt  (acc_nxt)
  );

  sincdec_comb #(
    .ACC_W  (ACC_W),
    .RATIO_W(RATIO_W),
    .OUT_W  (OUT_W)
  ) comb_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (reconfig),
    .dump        (dump),
    .order       (order),
    .ratio       (ratio_q),
    .acc_nxt     (acc_nxt),
    .result      (result),
    .result_valid(result_valid)
  );

endmodule

// File: tb/sinc_decim_tb_top.sv
module sinc_decim_tb_top;

  localparam int RW    = 4;
  localparam int DEFR  = 4;
  localparam int OW    = 3 * RW + 2;
  localparam int LIMIT = 200000;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               mod_en = 1'b0;
  logic               mod_bit = 1'b0;
  logic [RW-1:0]      dec_ratio = '0;
  logic [1:0]         filt_mode = 2'd0;
  logic               reconfig = 1'b0;
  logic signed [OW-1:0] result;
  logic               result_valid;

  sinc_decim #(.RATIO_W(RW), .DEF_RATIO(DEFR), .DEF_MODE(2'd2)) dut_i (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .mod_bit(mod_bit),
    .dec_ratio(dec_ratio), .filt_mode(filt_mode), .reconfig(reconfig),
    .result(result), .result_valid(result_valid)
  );

  always #5 clk = ~clk;

  int     checks = 0;
  int     errors = 0;
  bit     done = 1'b0;
  bit     reported = 1'b0;
  int     lfsr = 32'h1ACE;

  // reference model state
  int     hist[$];
  int     m_cnt, m_conv, m_ratio, m_mode;
  bit     exp_val;
  longint exp_res;
  string  cur_tag;

  function automatic bit rnd();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
    return lfsr[0];
  endfunction

  // boxcar of length r convolved with itself k times, applied to the history
  function automatic longint boxsum(int k, int r);
    int h[];
    int t[];
    longint acc;
    h = new[r];
    foreach (h[i]) h[i] = 1;
    for (int p = 1; p < k; p++) begin
      t = new[h.size() + r - 1];
      foreach (t[i]) t[i] = 0;
      foreach (h[i]) for (int j = 0; j < r; j++) t[i + j] += h[i];
      h = t;
    end
    acc = 0;
    for (int j = 0; j < h.size(); j++)
      if (hist.size() - 1 - j >= 0) acc += longint'(h[j]) * hist[hist.size() - 1 - j];
    return acc;
  endfunction

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  task automatic compare(string tag);
    string lbl;
    lbl = exp_val ? tag : {"R10 hold / ", tag};
    checks++;
    if (result_valid !== exp_val || longint'(result) != exp_res) begin
      errors++;
      $display("FAIL %s: valid=%0b result=%0d expected valid=%0b result=%0d",
               lbl, result_valid, result, exp_val, exp_res);
    end
  endtask

  task automatic model_step(bit rc, bit en, bit b, int m, int r);
    int k;
    longint y, r3;
    exp_val = 1'b0;
    if (rc) begin
      hist.delete();
      m_cnt = 0; m_conv = 0;
      m_ratio = (r < 2) ? 2 : r;
      m_mode = m;
    end else if (en) begin
      hist.push_back(int'(b));
      if (hist.size() > 3 * m_ratio) void'(hist.pop_front());
      m_cnt++;
      if (m_cnt == m_ratio) begin
        m_cnt = 0;
        m_conv++;
        if (m_mode == 0)      k = 1;
        else if (m_mode == 1) k = 2;
        else if (m_mode == 2) k = 3;
        else k = (m_conv == 1) ? 1 : (m_conv == 2) ? 2 : 3;
        y = boxsum(k, m_ratio);
        for (int p = k; p < 3; p++) y = y * m_ratio;
        r3 = longint'(m_ratio) * m_ratio * m_ratio;
        exp_res = 2 * y - r3;
        exp_val = 1'b1;
      end
    end
  endtask

  // one clock: check last edge's outcome, drive the next inputs, advance the model
  task automatic cycle(bit rc, bit en, bit b, int m, int r, string tag);
    @(negedge clk);
    compare(cur_tag);
    reconfig  = rc;
    mod_en    = en;
    mod_bit   = b;
    filt_mode = m[1:0];
    dec_ratio = r[RW-1:0];
    model_step(rc, en, b, m, r);
    cur_tag = tag;
  endtask

  // en_kind: 0 every cycle, 1 pseudo-random gaps; bit_kind: 0 random, 1 ones, 2 zeros
  task automatic seg(bit rc, int m, int r, int en_kind, int bit_kind, int len, string tag);
    for (int i = 0; i < len; i++) begin
      bit en, b;
      en = (en_kind == 0) ? 1'b1 : rnd();
      b  = (bit_kind == 0) ? rnd() : (bit_kind == 1);
      cycle(rc && i == 0, en, b, m, r, tag);
    end
  endtask

  initial begin
    #(LIMIT * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    m_ratio = DEFR; m_mode = 2; m_cnt = 0; m_conv = 0;
    exp_val = 1'b0; exp_res = 0; cur_tag = "R1 after reset";
    repeat (3) @(negedge clk);
    checks++;
    if (result_valid !== 1'b0 || result !== '0) begin
      errors++;
      $display("FAIL R1 in reset: valid=%0b result=%0d expected valid=0 result=0",
               result_valid, result);
    end
    rst_n = 1'b1;

    seg(1'b0, 0, 9, 0, 0, 40, "R5 R1 defaults sinc3");
    seg(1'b1, 0, 5, 0, 0, 50, "R3 fast");
    seg(1'b1, 1, 6, 1, 0, 90, "R4 R2 sinc2 gapped enable");
    seg(1'b1, 2, 7, 0, 0, 60, "R5 sinc3");
    seg(1'b1, 3, 4, 1, 0, 80, "R6 auto sequence");
    seg(1'b0, 0, 9, 0, 0, 40, "R8 inputs ignored");
    seg(1'b1, 3, 0, 0, 0, 30, "R9 ratio 0 clamp");
    seg(1'b1, 2, 1, 0, 0, 30, "R9 ratio 1 clamp");
    seg(1'b1, 3, 15, 0, 1, 100, "R11 all ones");
    seg(1'b1, 3, 15, 0, 2, 60, "R11 all zeros");
    seg(1'b1, 1, 5, 0, 1, 12, "R7 prefill");
    seg(1'b1, 2, 5, 0, 0, 40, "R7 reconfig mid conversion");
    seg(1'b1, 2, 15, 1, 0, 120, "R10 sinc3 max ratio");
    cycle(1'b0, 1'b0, 1'b0, 0, 0, "R10 idle");
    cycle(1'b0, 1'b0, 1'b0, 0, 0, "R10 idle");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule